// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic datapath of a small accumulator machine with a byte-wide data path. Each cycle it takes an operation code, the accumulator value and one operand. It returns the result, a write strobe for the destination, and the five status flags that the operation leaves behind. The result and the write strobe are combinational from the inputs and the current flags. The flags are held in a register inside the block and change on the clock edge that ends an accepted operation.

Each operation has its own rule for which flags it changes. Arithmetic and logic operations update all five flags. Increment and decrement leave carry alone. Rotates, set-carry and complement-carry change carry only. Complementing the accumulator touches no flag. The block also evaluates the eight branch conditions from the registered flags every cycle, so a sequencer can pick a condition by indexing one vector.

The data width is a parameter and must be even and at least 4. The half carry is taken at the middle of the word. A second parameter chooses between an inferred adder and an explicit ripple chain.

Top module: `acc_alu`

## Requirements
- R1: While reset is active, and after it ends, the flag vector `flags_o` reads 0. Its bit positions are: bit 4 sign S, bit 3 zero Z, bit 2 half carry H, bit 1 parity P, bit 0 carry CY.
- R2: ADD (code 0) produces acc+opnd and ADC (code 1) produces acc+opnd+CY. CY is the carry out of the top bit. H is the carry from bit 3 into bit 4: 0Fh+08h gives 17h with H=1.
- R3: SUB (code 2) produces acc−opnd and SBB (code 3) produces acc−opnd−CY. CY is set when a borrow occurs, which is when the unsigned subtrahend plus the carry-in exceeds acc. H is set on a borrow out of the low four bits.
- R4: Every operation that updates all flags sets S to result bit 7, sets Z when the result is zero, and sets P when the result has an even number of 1 bits.
- R5: INC (code 8) writes opnd+1 and DEC (code 9) writes opnd−1. They update S, Z, P and H (H=1 when INC starts from a low nibble of Fh, or when DEC starts from a low nibble of 0h) and leave CY unchanged.
- R6: CMP (code 7) sets the flags exactly as SUB would with the same inputs, and `wr_en_o` stays 0.
- R7: AND (4), XOR (5) and OR (6) write the bitwise result, update S, Z and P, and clear both CY and H.
- R8: RLC (10) rotates left and copies bit 7 into CY and into bit 0. RRC (11) rotates right and copies bit 0 into CY and into bit 7. RAL (12) and RAR (13) rotate through CY. All four change only CY.
- R9: CPL (14) writes the bitwise inverse of acc and changes no flag.
- R10: STC (15) sets CY and CMC (16) inverts CY. Neither writes a result, and neither changes any other flag.
- R11: `cond_hit_o` bit k is true for condition k, with conditions in this order: 0 Z=0, 1 Z=1, 2 S=0, 3 S=1, 4 P=0, 5 P=1, 6 CY=0, 7 CY=1.
- R12: When `op_valid_i` is low, or the code is 17 to 31, `wr_en_o` is 0 and no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the flag register |
| op_valid_i | input | 1 | Operation is accepted at this edge |
| op_code_i | input | 5 | Operation select |
| acc_i | input | W | Accumulator value |
| opnd_i | input | W | Second operand, or the target for INC/DEC |
| result_o | output | W | Operation result |
| wr_en_o | output | 1 | Destination write strobe |
| flags_o | output | 5 | Registered flags {S,Z,H,P,CY} |
| cond_hit_o | output | 8 | One bit per branch condition |

## Verification
The bench builds two copies at the default width of 8: one with the inferred adder and one with the explicit ripple chain. A single behavioural model is checked against both on every operation, so any difference in carry or half carry between the two adder variants shows up as a mismatch. Width 8 makes every nibble boundary, overflow wrap and parity pattern reachable with the operand values used. Directed cases cover the flag corners, and a long run of mixed random operations, including idle cycles and unused codes, covers how the flag-preservation rules combine from one operation to the next.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;

   // operation codes seen on op_code_i
   typedef enum logic [4:0] {
      OP_ADD = 5'd0,
      OP_ADC = 5'd1,
      OP_SUB = 5'd2,
      OP_SBB = 5'd3,
      OP_AND = 5'd4,
      OP_XOR = 5'd5,
      OP_OR  = 5'd6,
      OP_CMP = 5'd7,
      OP_INC = 5'd8,
      OP_DEC = 5'd9,
      OP_RLC = 5'd10,
      OP_RRC = 5'd11,
      OP_RAL = 5'd12,
      OP_RAR = 5'd13,
      OP_CPL = 5'd14,
      OP_STC = 5'd15,
      OP_CMC = 5'd16
   } alu_op_e;

   // flag vector layout
   localparam int FL_CY = 0;
   localparam int FL_P  = 1;
   localparam int FL_H  = 2;
   localparam int FL_Z  = 3;
   localparam int FL_S  = 4;
   localparam int FL_W  = 5;

   // which flags an operation may touch
   typedef enum logic [1:0] {
      UPD_NONE   = 2'd0,
      UPD_ALL    = 2'd1,
      UPD_NOCY   = 2'd2,
      UPD_CYONLY = 2'd3
   } upd_e;

endpackage

// File: rtl/acc_alu_addsub.sv
`timescale 1ns/1ps
module acc_alu_addsub #(
   parameter int W      = 8,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         sub_i,
   input  logic         cin_i,
   output logic [W-1:0] sum_o,
   output logic         co_o,
   output logic         hc_o
);
   localparam int HW = W / 2;

   if (W < 4 || (W % 2) != 0) begin : g_bad_width
      $error("acc_alu_addsub: W must be even and at least 4");
   end

   logic [W-1:0] b_x;
   logic         c0;

   // subtraction as a + ~b + ~cin; carry then means "no borrow"
   assign b_x = sub_i ? ~b_i : b_i;
   assign c0  = sub_i ^ cin_i;

   if (RIPPLE) begin : g_ripple
      logic [W:0] c;
      assign c[0] = c0;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign sum_o[i] = a_i[i] ^ b_x[i] ^ c[i];
         assign c[i+1]   = (a_i[i] & b_x[i]) | (a_i[i] & c[i]) | (b_x[i] & c[i]);
      end
      assign co_o = c[W] ^ sub_i;
      assign hc_o = c[HW] ^ sub_i;
   end else begin : g_infer
      logic [W:0] full;
      assign full  = {1'b0, a_i} + {1'b0, b_x} + {{W{1'b0}}, c0};
      assign sum_o = full[W-1:0];
      assign co_o  = full[W] ^ sub_i;
      // carry into the middle bit, recovered from that bit's sum
      assign hc_o  = (full[HW] ^ a_i[HW] ^ b_x[HW]) ^ sub_i;
   end

endmodule

// File: rtl/acc_alu_shlog.sv
`timescale 1ns/1ps
module acc_alu_shlog
   import acc_alu_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [4:0]   op_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cy_i,
   output logic [W-1:0] res_o,
   output logic         co_o
);
   always_comb begin
      res_o = a_i;
      co_o  = cy_i;
      case (op_i)
         OP_AND: res_o = a_i & b_i;
         OP_XOR: res_o = a_i ^ b_i;
         OP_OR:  res_o = a_i | b_i;
         OP_RLC: begin
            res_o = {a_i[W-2:0], a_i[W-1]};
            co_o  = a_i[W-1];
         end
         OP_RRC: begin
            res_o = {a_i[0], a_i[W-1:1]};
            co_o  = a_i[0];
         end
         OP_RAL: begin
            res_o = {a_i[W-2:0], cy_i};
            co_o  = a_i[W-1];
         end
         OP_RAR: begin
            res_o = {cy_i, a_i[W-1:1]};
            co_o  = a_i[0];
         end
         OP_CPL: res_o = ~a_i;
         default: begin
            res_o = a_i;
            co_o  = cy_i;
         end
      endcase
   end
endmodule

// File: rtl/acc_alu_flags.sv
`timescale 1ns/1ps
module acc_alu_flags
   import acc_alu_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  upd_e            upd_i,
   input  logic [FL_W-1:0] nxt_i,
   output logic [FL_W-1:0] flags_o,
   output logic [7:0]      cond_o
);
   logic [FL_W-1:0] mask;
   logic [FL_W-1:0] flg_q;

   always_comb begin
      case (upd_i)
         UPD_ALL:    mask = '1;
         UPD_NOCY:   mask = ~(FL_W'(1) << FL_CY);
         UPD_CYONLY: mask = FL_W'(1) << FL_CY;
         default:    mask = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) flg_q <= '0;
      else        flg_q <= (nxt_i & mask) | (flg_q & ~mask);
   end

   assign flags_o = flg_q;

   // condition k tests flag src_of(k/2); odd k wants it set
   function automatic int src_of(input int k);
      case (k)
         0:       return FL_Z;
         1:       return FL_S;
         2:       return FL_P;
         default: return FL_CY;
      endcase
   endfunction

   for (genvar k = 0; k < 4; k++) begin : g_cond
      assign cond_o[2*k]   = ~flg_q[src_of(k)];
      assign cond_o[2*k+1] =  flg_q[src_of(k)];
   end

   // R8
   cyonly_keeps_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_i == UPD_CYONLY) |=> (flags_o[FL_W-1:1] == $past(flags_o[FL_W-1:1])));

   // R5
   nocy_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_i == UPD_NOCY) |=> (flags_o[FL_CY] == $past(flags_o[FL_CY])));

endmodule

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int W      = 8,
   parameter bit RIPPLE = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          op_valid_i,
   input  logic [4:0]    op_code_i,
   input  logic [W-1:0]  acc_i,
   input  logic [W-1:0]  opnd_i,
   output logic [W-1:0]  result_o,
   output logic          wr_en_o,
   output logic [4:0]    flags_o,
   output logic [7:0]    cond_hit_o
);
   if (W < 4 || (W % 2) != 0) begin : g_bad_width
      $error("acc_alu: W must be even and at least 4");
   end

   logic [W-1:0]    ad_a, ad_b, ad_sum;
   logic            ad_sub, ad_cin, ad_co, ad_hc;
   logic [W-1:0]    lg_res;
   logic            lg_co;
   logic [W-1:0]    res;
   logic            wr, cy_n, h_n;
   upd_e            upd;
   logic [FL_W-1:0] flg, nxt;

   acc_alu_addsub #(.W(W), .RIPPLE(RIPPLE)) u_addsub (
      .a_i   (ad_a),
      .b_i   (ad_b),
      .sub_i (ad_sub),
      .cin_i (ad_cin),
      .sum_o (ad_sum),
      .co_o  (ad_co),
      .hc_o  (ad_hc)
   );

   acc_alu_shlog #(.W(W)) u_shlog (
      .op_i  (op_code_i),
      .a_i   (acc_i),
      .b_i   (opnd_i),
      .cy_i  (flg[FL_CY]),
      .res_o (lg_res),
      .co_o  (lg_co)
   );

   always_comb begin
      ad_a   = acc_i;
      ad_b   = opnd_i;
      ad_sub = 1'b0;
      ad_cin = 1'b0;
      res    = acc_i;
      wr     = 1'b0;
      upd    = UPD_NONE;
      cy_n   = flg[FL_CY];
      h_n    = 1'b0;
      case (op_code_i)
         OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP: begin
            ad_sub = (op_code_i == OP_SUB) || (op_code_i == OP_SBB) || (op_code_i == OP_CMP);
            ad_cin = ((op_code_i == OP_ADC) || (op_code_i == OP_SBB)) && flg[FL_CY];
            res    = ad_sum;
            wr     = (op_code_i != OP_CMP);
            upd    = UPD_ALL;
            cy_n   = ad_co;
            h_n    = ad_hc;
         end
         OP_INC, OP_DEC: begin
            ad_a   = opnd_i;
            ad_b   = W'(1);
            ad_sub = (op_code_i == OP_DEC);
            res    = ad_sum;
            wr     = 1'b1;
            upd    = UPD_NOCY;
            h_n    = ad_hc;
         end
         OP_AND, OP_XOR, OP_OR: begin
            res  = lg_res;
            wr   = 1'b1;
            upd  = UPD_ALL;
            cy_n = 1'b0;
         end
         OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
            res  = lg_res;
            wr   = 1'b1;
            upd  = UPD_CYONLY;
            cy_n = lg_co;
         end
         OP_CPL: begin
            res = lg_res;
            wr  = 1'b1;
         end
         OP_STC: begin
            upd  = UPD_CYONLY;
            cy_n = 1'b1;
         end
         OP_CMC: begin
            upd  = UPD_CYONLY;
            cy_n = ~flg[FL_CY];
         end
         default: begin
            wr  = 1'b0;
            upd = UPD_NONE;
         end
      endcase
      if (!op_valid_i) begin
         wr  = 1'b0;
         upd = UPD_NONE;
      end
   end

   always_comb begin
      nxt        = '0;
      nxt[FL_S]  = res[W-1];
      nxt[FL_Z]  = (res == '0);
      nxt[FL_P]  = ~(^res);
      nxt[FL_H]  = h_n;
      nxt[FL_CY] = cy_n;
   end

   acc_alu_flags u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd_i   (upd),
      .nxt_i   (nxt),
      .flags_o (flg),
      .cond_o  (cond_hit_o)
   );

   assign result_o = res;
   assign wr_en_o  = wr;
   assign flags_o  = flg;

   // R4
   zero_tracks_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && op_code_i <= 5'd7) |=> (flags_o[FL_Z] == ($past(result_o) == '0)));

   // R4
   parity_tracks_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && op_code_i <= 5'd7) |=> (flags_o[FL_P] == ~(^$past(result_o))));

   // R9
   cpl_no_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && op_code_i == OP_CPL) |=> $stable(flags_o));

   // R10
   stc_sets_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && op_code_i == OP_STC) |=> flags_o[FL_CY]);

   // R12
   idle_holds_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_valid_i || op_code_i > 5'd16) |=> $stable(flags_o));

   // R6
   cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code_i == OP_CMP) |-> !wr_en_o);

endmodule

// File: tb/acc_alu_tb_top.sv
`timescale 1ns/1ps
module acc_alu_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [4:0] op_code = '0;
   logic [7:0] acc = '0, opnd = '0;
   logic [7:0] res_a, res_b;
   logic       wr_a, wr_b;
   logic [4:0] fl_a, fl_b;
   logic [7:0] cd_a, cd_b;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // model flags
   int m_s = 0, m_z = 0, m_h = 0, m_p = 0, m_cy = 0;

   always #4 clk = ~clk;  // 8 ns period

   acc_alu #(.W(8), .RIPPLE(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid), .op_code_i(op_code),
      .acc_i(acc), .opnd_i(opnd), .result_o(res_a), .wr_en_o(wr_a),
      .flags_o(fl_a), .cond_hit_o(cd_a));

   acc_alu #(.W(8), .RIPPLE(1'b1)) dut_rip_i (
      .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid), .op_code_i(op_code),
      .acc_i(acc), .opnd_i(opnd), .result_o(res_b), .wr_en_o(wr_b),
      .flags_o(fl_b), .cond_hit_o(cd_b));

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic string tag_of(input int op, input bit v);
      if (!v || op > 16) return "R12";
      case (op)
         0, 1:         return "R2";
         2, 3:         return "R3";
         4, 5, 6:      return "R7";
         7:            return "R6";
         8, 9:         return "R5";
         10, 11, 12, 13: return "R8";
         14:           return "R9";
         default:      return "R10";
      endcase
   endfunction

   function automatic int exp_flags();
      return (m_s << 4) | (m_z << 3) | (m_h << 2) | (m_p << 1) | m_cy;
   endfunction

   function automatic int exp_cond();
      int z = m_z, s = m_s, p = m_p, c = m_cy;
      return ((1 - z) << 0) | (z << 1) | ((1 - s) << 2) | (s << 3) |
             ((1 - p) << 4) | (p << 5) | ((1 - c) << 6) | (c << 7);
   endfunction

   task automatic check_state(input string tag);
      chk(tag, "flags", int'(fl_a), exp_flags());
      chk(tag, "flags ripple", int'(fl_b), exp_flags());
      chk("R11", "cond", int'(cd_a), exp_cond());
      chk("R11", "cond ripple", int'(cd_b), exp_cond());
   endtask

   // one operation: drive at negedge, check outputs, commit model at posedge
   task automatic run_op(input int op, input int a, input int b, input bit v);
      int r = a, wr = 0, upd = 0, t, cin, ns, nz, nh, np, ncy;
      string tg;
      @(negedge clk);
      tg = tag_of(op, v);
      check_state(tg);
      op_valid = v; op_code = 5'(op); acc = 8'(a); opnd = 8'(b);
      nh = 0; ncy = m_cy;
      case (op)
         0, 1: begin
            cin = (op == 1) ? m_cy : 0;
            t = a + b + cin; r = t & 255; ncy = (t > 255);
            nh = (((a & 15) + (b & 15) + cin) > 15); wr = 1; upd = 1;
         end
         2, 3, 7: begin
            cin = (op == 3) ? m_cy : 0;
            t = a - b - cin; r = t & 255; ncy = (t < 0);
            nh = (((a & 15) - (b & 15) - cin) < 0); wr = (op != 7); upd = 1;
         end
         4: begin r = a & b; ncy = 0; wr = 1; upd = 1; end
         5: begin r = a ^ b; ncy = 0; wr = 1; upd = 1; end
         6: begin r = a | b; ncy = 0; wr = 1; upd = 1; end
         8: begin r = (b + 1) & 255; nh = ((b & 15) == 15); wr = 1; upd = 2; end
         9: begin r = (b - 1) & 255; nh = ((b & 15) == 0); wr = 1; upd = 2; end
         10: begin r = ((a << 1) | (a >> 7)) & 255; ncy = (a >> 7) & 1; wr = 1; upd = 3; end
         11: begin r = ((a >> 1) | (a << 7)) & 255; ncy = a & 1; wr = 1; upd = 3; end
         12: begin r = ((a << 1) | m_cy) & 255; ncy = (a >> 7) & 1; wr = 1; upd = 3; end
         13: begin r = (a >> 1) | (m_cy << 7); ncy = a & 1; wr = 1; upd = 3; end
         14: begin r = (~a) & 255; wr = 1; upd = 0; end
         15: begin ncy = 1; upd = 3; end
         16: begin ncy = 1 - m_cy; upd = 3; end
         default: begin wr = 0; upd = 0; end
      endcase
      if (!v) begin wr = 0; upd = 0; end
      ns = (r >> 7) & 1; nz = (r == 0); np = ($countones(8'(r)) % 2 == 0);
      #1;
      chk(tg, "wr_en", int'(wr_a), wr);
      chk(tg, "wr_en ripple", int'(wr_b), wr);
      if (wr != 0) begin
         chk(tg, "result", int'(res_a), r);
         chk(tg, "result ripple", int'(res_b), r);
      end
      @(posedge clk);
      if (upd == 1) begin m_s = ns; m_z = nz; m_p = np; m_h = nh; m_cy = ncy; end
      else if (upd == 2) begin m_s = ns; m_z = nz; m_p = np; m_h = nh; end
      else if (upd == 3) begin m_cy = ncy; end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk("R1", "flags in reset", int'(fl_a), 0);
      chk("R1", "wr_en in reset", int'(wr_a), 0);
      chk("R11", "cond in reset", int'(cd_a), 8'h55);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "flags after reset", int'(fl_b), 0);

      // R2 half carry example, then carry out and ADC
      run_op(0, 8'h0F, 8'h08, 1);
      run_op(0, 8'hF0, 8'h10, 1);   // zero result with carry: R4
      run_op(1, 8'h01, 8'h01, 1);   // ADC with CY=1
      // R3 borrow cases
      run_op(2, 8'h05, 8'h06, 1);
      run_op(3, 8'h10, 8'h0F, 1);
      run_op(2, 8'h80, 8'h00, 1);   // sign, R4
      // R6 compare equal
      run_op(7, 8'h33, 8'h33, 1);
      run_op(7, 8'h20, 8'h40, 1);
      // R5 inc/dec keep carry
      run_op(15, 0, 0, 1);
      run_op(8, 0, 8'hFF, 1);
      run_op(9, 0, 8'h00, 1);
      run_op(9, 0, 8'h10, 1);
      // R7 logic clears carry
      run_op(4, 8'hF0, 8'h3C, 1);
      run_op(5, 8'hAA, 8'hAA, 1);
      run_op(6, 8'h01, 8'h02, 1);
      // R8 rotates
      run_op(10, 8'h81, 0, 1);
      run_op(11, 8'h01, 0, 1);
      run_op(12, 8'h40, 0, 1);
      run_op(13, 8'h02, 0, 1);
      // R9, R10
      run_op(14, 8'h5A, 0, 1);
      run_op(16, 0, 0, 1);
      run_op(16, 0, 0, 1);
      // R12 idle and unused codes
      run_op(0, 8'hFF, 8'hFF, 0);
      run_op(20, 8'hFF, 8'h01, 1);
      run_op(31, 8'h00, 8'h00, 1);
      // mixed random traffic
      for (int i = 0; i < 4000; i++) begin
         int op = int'($urandom_range(0, 18));
         if (op > 16) op = int'($urandom_range(17, 31));
         run_op(op, int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                ($urandom_range(0, 9) != 0));
      end
      @(negedge clk);
      check_state("R12");
      summary();
   end
endmodule